// File: doc/BRIEF.md
# Oversampled Serial Frame Transmitter

This block turns one parallel word into an asynchronous serial frame on a single output line. All timing comes from a one-cycle strobe that runs at sixteen times the baud rate. The strobe is produced elsewhere. The transmitter counts strobes to shape every bit. While the line is quiet it rests high. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period.

A host waits until `busy` is low and then pulses `load` for one cycle. On that cycle the block captures the data word and the three format selects: data length, parity mode and stop length. These captured values fix the whole frame. Changes on the inputs while a frame is in flight have no effect. The stop period can be set in half-bit steps, which a sixteen-tick bit time makes exact: 8, 16 or 24 ticks.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, `busy` is 0 and `tx` is 1.
- R2: A `load` pulse starts a frame only on a cycle where `busy` is 0. A pulse while `busy` is 1 is ignored and queues nothing.
- R3: The cycle after an accepted load, `tx` goes to 0. It stays 0 for exactly 16 `tick16` strobes. A strobe that arrives on the load cycle itself is not counted.
- R4: Data bits follow the start bit, least significant bit first, each lasting 16 strobes. `len_sel` gives the count: 0 gives 6 bits, 1 gives 7 bits, and 2 or 3 give 8 bits. Input bits above the selected length are never sent.
- R5: `par_sel` sets the parity bit, which lasts 16 strobes after the last data bit. A value of 1 sends the XOR of the sent data bits. A value of 2 sends its inverse. A value of 0 or 3 sends no parity bit.
- R6: The frame ends with `tx` at 1 for a stop period set by `stop_sel`: 8 strobes for 0, 16 strobes for 1 or 3, and 24 strobes for 2.
- R7: `busy` rises on the cycle after an accepted load. It falls on the clock edge that takes the last stop strobe, so a new load may be accepted on the very next cycle.
- R8: The word and all three selects are captured at load time. Changing `data_in`, `len_sel`, `par_sel` or `stop_sel` during a frame does not change that frame.
- R9: The frame advances only on `tick16`. With no strobes, `tx` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16x the baud rate |
| load | input | 1 | Start a frame with the current word and selects |
| data_in | input | DATA_MAX (8) | Word to send |
| len_sel | input | 2 | Data length select |
| par_sel | input | 2 | Parity mode select |
| stop_sel | input | 2 | Stop length select |
| busy | output | 1 | High while a frame is in flight |
| tx | output | 1 | Serial line output |

## Verification
The assertions assume that `load` and `tick16` are single-cycle synchronous strobes and that `tick16` is never high on two edges in a row faster than the logic can step. They also assume that the inputs are known once reset is released. The stimulus drives every input on the falling clock edge. It produces strobes either on every second cycle or from a shift-register pattern that leaves gaps, and sometimes turns them off completely. It issues loads only as one-cycle pulses. Some of those pulses deliberately land while a frame is in progress, so that the ignore rule is exercised.

// File: rtl/sft_pkg.sv
// Shared types for the serial frame transmitter.
// Assumes: the select encodings listed here match the requirement list.
package sft_pkg;
    // Frame sequencing states; IDLE is the only state with busy low.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } phase_e;

    // Parity select encodings (others mean no parity bit).
    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    // Stop length encodings (3 is treated as one full bit).
    localparam logic [1:0] STOP_HALF    = 2'd0;
    localparam logic [1:0] STOP_ONEHALF = 2'd2;

    // Format selects captured together at load time.
    typedef struct packed {
        logic [1:0] len_code;
        logic [1:0] par_code;
        logic [1:0] stop_code;
    } frame_cfg_t;
endpackage

// File: rtl/sft_frame_latch.sv
// Frame latch: captures the word and format on an accepted load and
// derives the bit count, parity bit and stop duration for the frame.
// Assumes: DATA_MAX >= 3, OVERSAMPLE even; capture and shift never coincide.
module sft_frame_latch #(
    parameter int DATA_MAX   = 8,
    parameter int OVERSAMPLE = 16,
    parameter int IDX_W      = $clog2(DATA_MAX + 1),
    parameter int CNT_W      = $clog2(OVERSAMPLE * 3 / 2 + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic                   shift,
    input  logic [DATA_MAX-1:0]    data_in,
    input  sft_pkg::frame_cfg_t    cfg_in,
    output logic                   cur_bit,
    output logic [IDX_W-1:0]       nbits,
    output logic                   par_en,
    output logic                   par_bit,
    output logic [CNT_W-1:0]       stop_ticks
);
    import sft_pkg::*;

    localparam logic [CNT_W-1:0] HALF_T  = CNT_W'(OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] FULL_T  = CNT_W'(OVERSAMPLE);
    localparam logic [CNT_W-1:0] ONEH_T  = CNT_W'(OVERSAMPLE * 3 / 2);
    localparam logic [IDX_W-1:0] LEN_MAX = IDX_W'(DATA_MAX);

    logic [DATA_MAX-1:0] shreg_q;
    logic [DATA_MAX-1:0] len_mask;
    logic [IDX_W-1:0]    len_d;
    logic [CNT_W-1:0]    stop_d;
    logic                xor_d;

    // Decode the requested data length from the select code.
    always_comb begin
        case (cfg_in.len_code)
            2'd0:    len_d = LEN_MAX - IDX_W'(2);
            2'd1:    len_d = LEN_MAX - IDX_W'(1);
            default: len_d = LEN_MAX;
        endcase
    end

    // Build a mask covering only the bits that will be sent.
    always_comb begin
        for (int i = 0; i < DATA_MAX; i++) begin
            len_mask[i] = (IDX_W'(i) < len_d);
        end
    end

    // XOR of the bits that will actually be sent.
    assign xor_d = ^(data_in & len_mask);

    // Decode the stop period length in oversampling ticks.
    always_comb begin
        case (cfg_in.stop_code)
            STOP_HALF:    stop_d = HALF_T;
            STOP_ONEHALF: stop_d = ONEH_T;
            default:      stop_d = FULL_T;
        endcase
    end

    // Capture on load, shift right as each data bit completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            nbits      <= '0;
            par_en     <= 1'b0;
            par_bit    <= 1'b0;
            stop_ticks <= FULL_T;
        end else if (capture) begin
            shreg_q    <= data_in & len_mask;
            nbits      <= len_d;
            par_en     <= (cfg_in.par_code == PAR_EVEN) || (cfg_in.par_code == PAR_ODD);
            par_bit    <= (cfg_in.par_code == PAR_ODD) ? ~xor_d : xor_d;
            stop_ticks <= stop_d;
        end else if (shift) begin
            shreg_q    <= {1'b0, shreg_q[DATA_MAX-1:1]};
        end
    end

    assign cur_bit = shreg_q[0];
endmodule

// File: rtl/sft_tick_timer.sv
// Bit timer: counts oversampling ticks within the current bit and flags
// the tick that completes it.
// Assumes: limit >= 1 and stays constant within one bit.
module sft_tick_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = limit - CNT_W'(1);
    assign done = tick && (cnt_q == last);

    // Advance on ticks, wrap at the end of a bit, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sft_phase_ctrl.sv
// Phase controller: steps start, data, parity and stop phases as each bit
// completes, and tracks the data bit index.
// Assumes: nbits >= 1; bit_done only asserted while busy.
module sft_phase_ctrl #(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_done,
    input  logic [IDX_W-1:0]  nbits,
    input  logic              par_en,
    output sft_pkg::phase_e   phase,
    output logic              shift
);
    import sft_pkg::*;

    logic [IDX_W-1:0] idx_q;
    logic             last_data;

    assign last_data = (idx_q == nbits - IDX_W'(1));
    assign shift     = bit_done && (phase == PH_DATA);

    // Phase sequencing and data index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx_q <= '0;
        end else if (start) begin
            phase <= PH_START;
            idx_q <= '0;
        end else if (bit_done) begin
            case (phase)
                PH_START: begin
                    phase <= PH_DATA;
                    idx_q <= '0;
                end
                PH_DATA: begin
                    if (last_data) begin
                        phase <= par_en ? PH_PARITY : PH_STOP;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_PARITY: phase <= PH_STOP;
                PH_STOP:   phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
// Serial frame transmitter top: accepts a word when idle and sends
// start, data (LSB first), optional parity and stop on tx, timed by a
// 16x baud strobe.
// Assumes: tick16 and load are single-cycle synchronous strobes.
module serial_frame_tx #(
    parameter int DATA_MAX   = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                load,
    input  logic [DATA_MAX-1:0] data_in,
    input  logic [1:0]          len_sel,
    input  logic [1:0]          par_sel,
    input  logic [1:0]          stop_sel,
    output logic                busy,
    output logic                tx
);
    import sft_pkg::*;

    localparam int IDX_W = $clog2(DATA_MAX + 1);
    localparam int CNT_W = $clog2(OVERSAMPLE * 3 / 2 + 1);
    localparam logic [CNT_W-1:0] FULL_T = CNT_W'(OVERSAMPLE);

    phase_e           phase;
    frame_cfg_t       cfg;
    logic             load_ok;
    logic             bit_done;
    logic             shift;
    logic             cur_bit;
    logic             par_en;
    logic             par_bit;
    logic [IDX_W-1:0] nbits;
    logic [CNT_W-1:0] stop_ticks;
    logic [CNT_W-1:0] limit;

    assign cfg     = '{len_code: len_sel, par_code: par_sel, stop_code: stop_sel};
    assign busy    = (phase != PH_IDLE);
    assign load_ok = load && !busy;
    assign limit   = (phase == PH_STOP) ? stop_ticks : FULL_T;

    sft_frame_latch #(
        .DATA_MAX   (DATA_MAX),
        .OVERSAMPLE (OVERSAMPLE),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (load_ok),
        .shift      (shift),
        .data_in    (data_in),
        .cfg_in     (cfg),
        .cur_bit    (cur_bit),
        .nbits      (nbits),
        .par_en     (par_en),
        .par_bit    (par_bit),
        .stop_ticks (stop_ticks)
    );

    sft_tick_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!busy),
        .tick  (tick16 && busy),
        .limit (limit),
        .done  (bit_done)
    );

    sft_phase_ctrl #(
        .IDX_W (IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (load_ok),
        .bit_done (bit_done),
        .nbits    (nbits),
        .par_en   (par_en),
        .phase    (phase),
        .shift    (shift)
    );

    // Line level selected from the registered phase.
    always_comb begin
        case (phase)
            PH_START:  tx = 1'b0;
            PH_DATA:   tx = cur_bit;
            PH_PARITY: tx = par_bit;
            default:   tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/sft_tx_checker.sv
// Protocol checker for the serial frame transmitter, observing ports only.
// Assumes: bound to serial_frame_tx; reset is synchronous active-low.
module sft_tx_checker #(
    parameter int OVERSAMPLE = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic load,
    input logic busy,
    input logic tx
);
    logic [7:0] ticks_in_frame;

    // Count strobes since the frame began, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            ticks_in_frame <= '0;
        end else if (tick16 && ticks_in_frame != 8'hFF) begin
            ticks_in_frame <= ticks_in_frame + 8'd1;
        end
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    assert_start_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load));

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ticks_in_frame < OVERSAMPLE) |-> !tx);

    assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx));

    assert_busy_ends_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick16));

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$past(tick16)) |-> $stable(tx));
endmodule

bind serial_frame_tx sft_tx_checker #(.OVERSAMPLE(OVERSAMPLE)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick16 (tick16),
    .load   (load),
    .busy   (busy),
    .tx     (tx)
);

// File: tb/serial_frame_tx_tb_top.sv
// Bench: behavioural frame model (queue of levels and tick durations),
// compared with the design on every falling clock edge.
module serial_frame_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       load = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic [1:0] len_sel = 2'd0;
    logic [1:0] par_sel = 2'd0;
    logic [1:0] stop_sel = 2'd1;
    logic       busy;
    logic       tx;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    serial_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .load(load),
        .data_in(data_in), .len_sel(len_sel), .par_sel(par_sel),
        .stop_sel(stop_sel), .busy(busy), .tx(tx)
    );

    // Reference model state.
    bit    q_lvl[$];
    int    q_dur[$];
    string q_tag[$];
    bit    m_busy = 0;
    int    m_rem = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Build the expected bit list for one frame.
    task automatic build_frame(input logic [7:0] d, input logic [1:0] ln,
                               input logic [1:0] pm, input logic [1:0] sp);
        int nb;
        bit x;
        nb = (ln == 0) ? 6 : (ln == 1) ? 7 : 8;
        x = 0;
        q_lvl.push_back(0); q_dur.push_back(16); q_tag.push_back("R3");
        for (int i = 0; i < nb; i++) begin
            q_lvl.push_back(d[i]); q_dur.push_back(16); q_tag.push_back("R4");
            x = x ^ d[i];
        end
        if (pm == 1) begin
            q_lvl.push_back(x); q_dur.push_back(16); q_tag.push_back("R5");
        end else if (pm == 2) begin
            q_lvl.push_back(!x); q_dur.push_back(16); q_tag.push_back("R5");
        end
        q_lvl.push_back(1);
        q_dur.push_back(sp == 0 ? 8 : sp == 2 ? 24 : 16);
        q_tag.push_back("R6");
    endtask

    // Model update at the active edge, from inputs driven on the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_lvl.delete(); q_dur.delete(); q_tag.delete();
            m_busy = 0;
        end else if (m_busy) begin
            if (tick16) begin
                m_rem--;
                if (m_rem == 0) begin
                    void'(q_lvl.pop_front()); void'(q_dur.pop_front()); void'(q_tag.pop_front());
                    if (q_lvl.size() == 0) m_busy = 0;
                    else m_rem = q_dur[0];
                end
            end
        end else if (load) begin
            build_frame(data_in, len_sel, par_sel, stop_sel);
            m_busy = 1;
            m_rem = q_dur[0];
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check(busy == m_busy, "R7 busy", busy, m_busy);
            if (m_busy) check(tx == q_lvl[0], q_tag[0], tx, q_lvl[0]);
            else        check(tx == 1'b1, "R1 idle", tx, 1);
        end
    end

    // Strobe generator: every 2nd cycle, irregular pattern, or off.
    initial begin
        logic [7:0] lf = 8'h5B;
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            case (tick_mode)
                0:       tick16 = (n % 2 == 0);
                1:       tick16 = lf[0] & lf[2];
                default: tick16 = 1'b0;
            endcase
        end
    end

    task automatic send(input logic [7:0] d, input logic [1:0] ln,
                        input logic [1:0] pm, input logic [1:0] sp);
        @(negedge clk);
        while (busy) @(negedge clk);
        data_in = d; len_sel = ln; par_sel = pm; stop_sel = sp; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int e0;
        logic t0, b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(tx == 1'b1, "R1 reset tx", tx, 1);
        rst_n = 1'b1;

        // R3 R4 R5 R6: every length, parity and stop code
        tick_mode = 0;
        for (int c = 0; c < 64; c++) begin
            send(8'hA5 ^ 8'(c * 37), 2'(c / 16), 2'((c / 4) % 4), 2'(c % 4));
        end

        // R7: back-to-back frames with irregular strobes
        tick_mode = 1;
        for (int c = 0; c < 8; c++) send(8'(c * 53 + 7), 2'(c % 3), 2'(c % 3), 2'(c % 4));
        wait_idle();

        // R2 R8: load pulse and input changes during a frame
        tick_mode = 0;
        e0 = errors;
        send(8'h3C, 2'd2, 2'd1, 2'd2);
        repeat (20) @(negedge clk);
        data_in = 8'hFF; len_sel = 2'd0; par_sel = 2'd2; stop_sel = 2'd0; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (30) @(negedge clk);
        data_in = 8'h00; stop_sel = 2'd1;
        wait_idle();
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R2 ignored load", busy, 0);
        check(tx == 1'b1, "R2 ignored load tx", tx, 1);
        check(errors == e0, "R8 latched frame", errors - e0, 0);

        // R9: strobes stop mid-frame
        send(8'h96, 2'd2, 2'd0, 2'd1);
        repeat (50) @(negedge clk);
        tick_mode = 2;
        @(negedge clk);
        t0 = tx; b0 = busy;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            check(tx == t0, "R9 hold tx", tx, t0);
            check(busy == b0, "R9 hold busy", busy, b0);
        end
        tick_mode = 0;
        wait_idle();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule